// File: doc/BRIEF.md
# Protection Region Bounds Decoder

This block turns the settings of a bank of memory-protection entries into precomputed, inclusive byte ranges. Each entry has a configuration byte, which selects a match mode, and an address register, which holds a byte address shifted right by two. When an update command for an entry is accepted, the block decodes that entry and the entry directly above it into a low and a high byte address. The entry above is included because a top-of-range entry takes its lower bound from the address register of the entry below. In the same cycle the block recounts how many entries have a mode other than off.

All results sit in registers. A downstream permission checker can therefore compare an access address against every entry's range with one pair of comparators per entry. It never has to decode modes on the access path.

Update commands arrive on a valid/ready stream. `upd_ready` is high whenever reset is low, so the stream never applies back-pressure. A command is accepted on every rising edge that sees `upd_valid` and `upd_ready` both high, and a new command may be accepted on each cycle. The entry inputs are sampled on the accepting edge. For each accepted command the block raises `upd_done` for exactly one cycle, and the new table and count are visible from that same cycle.

Top module: `bounds_decoder`

## Requirements
- R1: While `rst` is high and after its release, before any update, every entry reads low = 0 and high = all ones, `active_cnt` is 0 and `upd_done` is low.
- R2: `upd_ready` is high whenever `rst` is low. One cycle after each accepted command, `upd_done` is high for exactly one cycle. The range table and `active_cnt` change only in that cycle. Changing the entry inputs without a command leaves every output unchanged.
- R3: The match mode is bits [4:3] of the configuration byte: 0 = off, 1 = top-of-range, 2 = naturally aligned 4 bytes, 3 = power-of-two. All other configuration bits are ignored. An off entry decodes to low = 0 and high = all ones.
- R4: A top-of-range entry decodes to low = (address register of the entry below) << 2 and high = (own address register << 2) − 1, computed modulo 2^(ADDR_W+2). Entry 0 uses 0 as the address below, so an own address of 0 gives high = all ones. Every decoded low has bits [1:0] = 00 and every decoded high has bits [1:0] = 11.
- R5: A 4-byte entry decodes to low = address << 2 and high = low + 3.
- R6: For a power-of-two entry, let t be the number of trailing one bits in the address register. The entry decodes to low = (register with its low t bits cleared) << 2 and high = low + 2^(t+3) − 1. The range is a power of two in size and aligned to its size.
- R7: A power-of-two entry whose address register is all ones decodes to low = 0 and high = all ones.
- R8: On each accepted command, `active_cnt` becomes the number of entries whose configuration mode, as sampled on the accepting edge, is not off.
- R9: A command for index i rewrites the ranges of entry i and entry i+1 (if that entry exists) and leaves every other entry unchanged, even when its inputs have changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfg_i | input | NUM_ENTRIES*8 | Configuration byte of each entry; mode in bits [4:3] |
| addr_i | input | NUM_ENTRIES*ADDR_W | Address register of each entry (byte address >> 2) |
| upd_valid | input | 1 | Update command valid |
| upd_ready | output | 1 | Update command ready (high whenever out of reset) |
| upd_idx | input | IDX_W | Index of the entry to recompute |
| rgn_lo | output | NUM_ENTRIES*(ADDR_W+2) | Inclusive low byte address of each entry |
| rgn_hi | output | NUM_ENTRIES*(ADDR_W+2) | Inclusive high byte address of each entry |
| active_cnt | output | CNT_W | Number of entries not in off mode |
| upd_done | output | 1 | One-cycle pulse when new results are visible |

## Verification
The assertions check, on every cycle, that the table and count change only in the cycle flagged by `upd_done`. They also check that every stored range keeps 4-byte granularity, that a 4-byte entry always spans exactly four bytes, and that every range not in top-of-range mode is aligned to its own power-of-two size. The exact bound values can only be shown by the bench scenarios, which a scoreboard compares item by item. These scenarios cover top-of-range bounds taken from the entry below, the recount of active entries, the refresh of the upper neighbour, wrap at address zero, and the extreme power-of-two sizes.

// File: rtl/bdec_pkg.sv
package bdec_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_t;

  localparam int MODE_LSB = 3;

  function automatic match_mode_t mode_of(input logic [7:0] cfg);
    return match_mode_t'(cfg[MODE_LSB +: 2]);
  endfunction

endpackage

// File: rtl/bdec_ones_mask.sv
// Marks the run of trailing one bits of a word: mask[k] is set when bits
// [k:0] are all ones. The top bit is not needed by the decoder.
module bdec_ones_mask #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] word_i,
  output logic [ADDR_W-2:0] mask_o
);

  assign mask_o[0] = word_i[0];

  genvar k;
  generate
    for (k = 1; k < ADDR_W - 1; k++) begin : g_chain
      assign mask_o[k] = mask_o[k-1] & word_i[k];
    end
  endgenerate

endmodule

// File: rtl/bdec_entry.sv
// Decodes one entry into an inclusive byte range.
module bdec_entry
  import bdec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  match_mode_t               mode_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [ADDR_W-1:0]         below_i,
  output logic [ADDR_W+1:0]         lo_o,
  output logic [ADDR_W+1:0]         hi_o
);

  localparam int BYTE_W = ADDR_W + 2;

  logic [ADDR_W-2:0] run_mask;
  logic [ADDR_W-1:0] clear_mask;
  logic [BYTE_W-1:0] own_byte;
  logic [BYTE_W-1:0] pow_base;
  logic [BYTE_W-1:0] pow_span;

  bdec_ones_mask #(.ADDR_W(ADDR_W)) u_mask (
    .word_i (addr_i),
    .mask_o (run_mask)
  );

  // Clearing one bit past the run is harmless: that bit is the first zero.
  assign clear_mask = {run_mask, 1'b1};
  assign own_byte   = {addr_i, 2'b00};
  assign pow_base   = {addr_i & ~clear_mask, 2'b00};
  assign pow_span   = {clear_mask, 2'b11};

  always_comb begin
    unique case (mode_i)
      MODE_TOR: begin
        lo_o = {below_i, 2'b00};
        hi_o = own_byte - BYTE_W'(1);
      end
      MODE_NA4: begin
        lo_o = own_byte;
        hi_o = own_byte | BYTE_W'(3);
      end
      MODE_NAPOT: begin
        lo_o = pow_base;
        hi_o = pow_base | pow_span;
      end
      default: begin
        lo_o = '0;
        hi_o = '1;
      end
    endcase
  end

endmodule

// File: rtl/bdec_popcount.sv
module bdec_popcount #(
  parameter int NUM_BITS = 8,
  parameter int CNT_W    = $clog2(NUM_BITS + 1)
) (
  input  logic [NUM_BITS-1:0] bits_i,
  output logic [CNT_W-1:0]    count_o
);

  always_comb begin
    count_o = '0;
    for (int k = 0; k < NUM_BITS; k++) begin
      count_o = count_o + CNT_W'(bits_i[k]);
    end
  end

endmodule

// File: rtl/bounds_decoder.sv
module bounds_decoder
  import bdec_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = $clog2(NUM_ENTRIES),
  parameter int CNT_W       = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [NUM_ENTRIES-1:0][7:0]          cfg_i,
  input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0]   addr_i,
  input  logic                                 upd_valid,
  output logic                                 upd_ready,
  input  logic [IDX_W-1:0]                     upd_idx,
  output logic [NUM_ENTRIES-1:0][ADDR_W+1:0]   rgn_lo,
  output logic [NUM_ENTRIES-1:0][ADDR_W+1:0]   rgn_hi,
  output logic [CNT_W-1:0]                     active_cnt,
  output logic                                 upd_done
);

  localparam int BYTE_W = ADDR_W + 2;

  logic                    upd_fire;
  logic [NUM_ENTRIES-1:0]  refresh;
  logic [NUM_ENTRIES-1:0]  live;
  logic [CNT_W-1:0]        live_cnt;
  match_mode_t             dec_mode [NUM_ENTRIES];
  match_mode_t             mode_q   [NUM_ENTRIES];
  logic [BYTE_W-1:0]       dec_lo   [NUM_ENTRIES];
  logic [BYTE_W-1:0]       dec_hi   [NUM_ENTRIES];
  logic [ADDR_W-1:0]       below    [NUM_ENTRIES];
  logic                    cfg_unused;

  assign upd_ready = ~rst;
  assign upd_fire  = upd_valid & upd_ready;

  always_comb begin
    cfg_unused = 1'b0;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      cfg_unused = cfg_unused ^ (^cfg_i[k][7:5]) ^ (^cfg_i[k][2:0]);
    end
  end

  genvar k;
  generate
    for (k = 0; k < NUM_ENTRIES; k++) begin : g_entry
      if (k == 0) begin : g_first
        assign below[k]   = '0;
        assign refresh[k] = upd_fire && (upd_idx == IDX_W'(0));
      end else begin : g_rest
        assign below[k]   = addr_i[k-1];
        assign refresh[k] = upd_fire && ((upd_idx == IDX_W'(k)) ||
                                         (upd_idx == IDX_W'(k - 1)));
      end

      assign dec_mode[k] = mode_of(cfg_i[k]);
      assign live[k]     = (dec_mode[k] != MODE_OFF);

      bdec_entry #(.ADDR_W(ADDR_W)) u_dec (
        .mode_i  (dec_mode[k]),
        .addr_i  (addr_i[k]),
        .below_i (below[k]),
        .lo_o    (dec_lo[k]),
        .hi_o    (dec_hi[k])
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          rgn_lo[k] <= '0;
          rgn_hi[k] <= '1;
          mode_q[k] <= MODE_OFF;
        end else if (refresh[k]) begin
          rgn_lo[k] <= dec_lo[k];
          rgn_hi[k] <= dec_hi[k];
          mode_q[k] <= dec_mode[k];
        end
      end

      // Range width minus one, used by the alignment checks below.
      logic [BYTE_W-1:0] span_q;
      assign span_q = rgn_hi[k] - rgn_lo[k];

      assert_word_grain_R4: assert property (@(posedge clk) disable iff (rst)
        (rgn_lo[k][1:0] == 2'b00) && (rgn_hi[k][1:0] == 2'b11));

      assert_na4_span_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q[k] == MODE_NA4) |-> (span_q == BYTE_W'(3)));

      // R6: ranges other than top-of-range are power-of-two sized and aligned.
      assert_pow_aligned_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_q[k] != MODE_TOR) |->
          (((span_q & (span_q + BYTE_W'(1))) == '0) && ((rgn_lo[k] & span_q) == '0)));
    end
  endgenerate

  bdec_popcount #(.NUM_BITS(NUM_ENTRIES), .CNT_W(CNT_W)) u_count (
    .bits_i  (live),
    .count_o (live_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_cnt <= '0;
      upd_done   <= 1'b0;
    end else begin
      upd_done <= upd_fire;
      if (upd_fire) begin
        active_cnt <= live_cnt;
      end
    end
  end

  assert_hold_between_R2: assert property (@(posedge clk) disable iff (rst)
    !upd_done |-> ($stable(rgn_lo) && $stable(rgn_hi) && $stable(active_cnt)));

endmodule

// File: tb/tb_bounds_decoder.sv
module tb_bounds_decoder;

  localparam int N  = 8;
  localparam int AW = 32;
  localparam int BW = AW + 2;
  localparam int IW = 3;
  localparam int CW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                      rst;
  logic [N-1:0][7:0]         cfg;
  logic [N-1:0][AW-1:0]      addr;
  logic                      upd_valid;
  logic                      upd_ready;
  logic [IW-1:0]             upd_idx;
  logic [N-1:0][BW-1:0]      rgn_lo;
  logic [N-1:0][BW-1:0]      rgn_hi;
  logic [CW-1:0]             active_cnt;
  logic                      upd_done;

  bounds_decoder #(.NUM_ENTRIES(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .cfg_i(cfg), .addr_i(addr),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_idx(upd_idx),
    .rgn_lo(rgn_lo), .rgn_hi(rgn_hi), .active_cnt(active_cnt),
    .upd_done(upd_done)
  );

  typedef struct packed {
    logic [N-1:0][BW-1:0] lo;
    logic [N-1:0][BW-1:0] hi;
    logic [CW-1:0]        cnt;
  } item_t;

  item_t                expq[$];
  string                tagq[$];
  logic [N-1:0][BW-1:0] m_lo;
  logic [N-1:0][BW-1:0] m_hi;
  logic [CW-1:0]        m_cnt;
  int                   checks = 0;
  int                   fails  = 0;

  // Reference decode, written from R3..R7.
  task automatic ref_decode(input logic [7:0] c, input logic [AW-1:0] a,
                            input logic [AW-1:0] below,
                            output logic [BW-1:0] lo, output logic [BW-1:0] hi);
    logic [63:0]   wide;
    logic [AW-1:0] b;
    int            t;
    case (c[4:3])
      2'd1: begin lo = {below, 2'b00}; hi = {a, 2'b00} - BW'(1); end
      2'd2: begin lo = {a, 2'b00}; hi = lo + BW'(3); end
      2'd3: begin
        t = 0;
        while (t < AW && a[t]) t++;
        if (t == AW) begin
          lo = '0; hi = '1;
        end else begin
          b = a;
          for (int j = 0; j < t; j++) b[j] = 1'b0;
          lo   = {b, 2'b00};
          wide = 64'(lo) + (64'd1 << (t + 3)) - 64'd1;
          hi   = wide[BW-1:0];
        end
      end
      default: begin lo = '0; hi = '1; end
    endcase
  endtask

  task automatic model_entry(input int k);
    logic [AW-1:0] below;
    below = (k == 0) ? '0 : addr[k-1];
    ref_decode(cfg[k], addr[k], below, m_lo[k], m_hi[k]);
  endtask

  task automatic compare(input item_t got, input item_t exp, input string tag);
    for (int k = 0; k < N; k++) begin
      checks++;
      if (got.lo[k] !== exp.lo[k] || got.hi[k] !== exp.hi[k]) begin
        fails++;
        $display("FAIL %s entry %0d: got lo=%h hi=%h expected lo=%h hi=%h",
                 tag, k, got.lo[k], got.hi[k], exp.lo[k], exp.hi[k]);
      end
    end
    checks++;
    if (got.cnt !== exp.cnt) begin
      fails++;
      $display("FAIL %s (R8) count: got %0d expected %0d", tag, got.cnt, exp.cnt);
    end
  endtask

  // Driver: computes the expected table, queues it, issues the command.
  task automatic upd(input int i, input string tag);
    item_t it;
    model_entry(i);
    if (i + 1 < N) model_entry(i + 1);
    m_cnt = '0;
    for (int k = 0; k < N; k++) if (cfg[k][4:3] != 2'd0) m_cnt = m_cnt + CW'(1);
    it.lo = m_lo; it.hi = m_hi; it.cnt = m_cnt;
    expq.push_back(it);
    tagq.push_back(tag);
    upd_valid = 1'b1;
    upd_idx   = IW'(i);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  // Direct port check against the model while idle (R1, R2).
  task automatic check_idle(input string tag);
    item_t got, exp;
    got.lo = rgn_lo; got.hi = rgn_hi; got.cnt = active_cnt;
    exp.lo = m_lo;   exp.hi = m_hi;   exp.cnt = m_cnt;
    compare(got, exp, tag);
    checks++;
    if (upd_done !== 1'b0 || upd_ready !== 1'b1) begin
      fails++;
      $display("FAIL %s (R2) handshake: got done=%b ready=%b expected done=0 ready=1",
               tag, upd_done, upd_ready);
    end
  endtask

  // Monitor: pops one expected item per done pulse.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && upd_done) begin
        item_t got;
        got.lo = rgn_lo; got.hi = rgn_hi; got.cnt = active_cnt;
        if (expq.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2 unexpected done pulse: got done=1 expected done=0");
        end else begin
          compare(got, expq.pop_front(), tagq.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got no completion expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; upd_valid = 1'b0; upd_idx = '0;
    cfg = '0; addr = '0;
    for (int k = 0; k < N; k++) begin m_lo[k] = '0; m_hi[k] = '1; end
    m_cnt = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (upd_ready !== 1'b0) begin
      fails++;
      $display("FAIL R2 ready in reset: got %b expected 0", upd_ready);
    end
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 reset state");

    // 4-byte entry, junk in the other configuration bits (R5, R3).
    cfg[2] = 8'h91; addr[2] = 32'h0000_1234;
    upd(2, "R5 na4");
    @(negedge clk);

    // Top-of-range from the entry below (R4).
    cfg[3] = 8'h08; addr[3] = 32'h0000_2000;
    upd(3, "R4 tor");
    @(negedge clk);

    // Entry below changes: its update also refreshes entry 3 (R9).
    addr[2] = 32'h0000_1000;
    upd(2, "R9 neighbour refresh");
    @(negedge clk);

    // Entry 0 top-of-range, own address 0 wraps to all ones (R4).
    cfg[0] = 8'h08; addr[0] = '0;
    upd(0, "R4 entry0 wrap");
    @(negedge clk);

    // Power-of-two sizes (R6, R7).
    cfg[4] = 8'h18; addr[4] = 32'h0000_4000;
    upd(4, "R6 napot 8 bytes");
    addr[4] = 32'h0000_401F;
    upd(4, "R6 napot t=5");
    addr[4] = 32'h7FFF_FFFF;
    upd(4, "R6 napot largest finite");
    addr[4] = 32'hFFFF_FFFF;
    upd(4, "R7 napot all ones");
    @(negedge clk);

    // Back-to-back commands, count grows (R8).
    cfg[5] = 8'h10; addr[5] = 32'h0000_0040;
    upd(5, "R8 count a");
    cfg[6] = 8'h18; addr[6] = 32'h0001_0007;
    upd(6, "R8 count b");
    @(negedge clk);

    // Top entry, off mode with garbage (R3).
    cfg[7] = 8'hE7; addr[7] = 32'hDEAD_BEEF;
    upd(7, "R3 off top entry");
    @(negedge clk);

    // Input changes without a command are not applied (R2, R9).
    addr[5] = 32'h0000_0999; cfg[1] = 8'h10; addr[1] = 32'h0000_0777;
    repeat (4) @(negedge clk);
    check_idle("R9 no command no change");

    // Command at 1 refreshes 1 and 2 only; entry 5 stays stale (R9).
    upd(1, "R9 others untouched");
    @(negedge clk);

    // Switching an entry off lowers the count (R3, R8).
    cfg[2] = 8'h00;
    upd(2, "R3 switch off");
    repeat (3) @(negedge clk);

    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R2 pending items: got %0d expected 0", expq.size());
    end
    finish_run();
  end

endmodule